// File: doc/BRIEF.md
# Selectable Clock Fanout with Per-Lane Falling-Edge Gating

The block picks one of two clocks and fans it out to a set of output lanes, six by default. A source select chooses between a fast system clock and a slower scan/test clock. Each lane drives a true output and a complement output. The differential system clock is carried here on its true leg only. Electrical levels, termination and skew are outside this block.

Each lane is held open or closed by a small state machine with two states, `GATE_OPEN` and `GATE_PARKED`. The machine is clocked on the falling edge of the selected clock. The *park* transition (`GATE_OPEN` to `GATE_PARKED`) is taken at a falling edge when the lane's own disable input or the shared disable input is high. The *resume* transition (`GATE_PARKED` to `GATE_OPEN`) is taken at a falling edge when both are low. Any other combination keeps the current state. Because the state can only change while the selected clock is low, opening or closing a lane never cuts a high pulse short. An active-low asynchronous reset forces every lane to `GATE_OPEN`. Undriven controls are meant to be pulled low, which selects the system clock with every lane enabled.

Top module: `clk_fanout_gated`

## Requirements
- R1: With `src_sel` = 0, every open lane's `clk_out_t` follows `clk_sys`, and `clk_scan` has no effect on it.
- R2: With `src_sel` = 1, every open lane's `clk_out_t` follows `clk_scan`, and `clk_sys` has no effect on it.
- R3: For every lane i, `clk_out_c[i]` is always the inverse of `clk_out_t[i]`, including while the lane is parked.
- R4: Bit i of `dis_lane` (1 = disable) controls lane i. When it is high at a falling edge of the selected clock, lane i parks: `clk_out_t[i]` stays 0 and `clk_out_c[i]` stays 1 from that edge on. The other lanes are unaffected.
- R5: When `dis_all` is high at a falling edge of the selected clock, every lane parks, whatever `dis_lane` holds.
- R6: A change on `dis_lane` or `dis_all` takes effect only at the next falling edge of the selected clock. When the change comes while the clock is high, the current high pulse completes. When it comes while the clock is low, the next high phase still uses the previous gating. No high pulse on any lane is shorter than one full high phase of the selected clock.
- R7: While `rst_n` is low, every lane is in `GATE_OPEN` regardless of the disable inputs. After release, gating follows the inputs from the first falling edge.
- R8: A parked lane whose disables all go low stays low for the rest of the current cycle. It resumes with a full high pulse at the first rising edge after the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | High-speed system clock (true leg) |
| clk_scan | input | 1 | Slower scan/test clock |
| src_sel | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| rst_n | input | 1 | Asynchronous active-low reset; opens every lane |
| dis_all | input | 1 | Shared disable, active high, acts on all lanes |
| dis_lane | input | LANES | Per-lane disable, active high, bit i for lane i |
| clk_out_t | output | LANES | True clock output of each lane |
| clk_out_c | output | LANES | Complement clock output of each lane |

## Verification
A lane machine stuck in or wrongly entering `GATE_PARKED` shows up at the very next high phase of the selected clock. The true output is then absent where a pulse is expected, or present where it should be held low. A machine that samples on the wrong edge, or a decode not qualified by the state, shows up at once as a shortened high pulse, and a width monitor on every lane measures each pulse against the half period. The bench sweeps every lane, both sources, every disable pattern, and changes made both mid-high and mid-low. A wrong source selection or a broken complement is visible in the first sampled phase.

// File: rtl/cfan_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the selectable clock fanout.
package cfan_pkg;

    // Default number of output lanes.
    localparam int unsigned CFAN_LANES = 6;

    // Gating state of one lane.
    typedef enum logic {
        GATE_OPEN   = 1'b0,
        GATE_PARKED = 1'b1
    } gate_state_e;

endpackage

// File: rtl/cfan_src_mux.sv
`timescale 1ns/1ps
// Two-way clock source selection; no glitch protection on a source change.
module cfan_src_mux (
    input  logic clk_sys,
    input  logic clk_scan,
    input  logic src_sel,
    output logic clk_sel
);

    always_comb begin
        if (src_sel) begin
            clk_sel = clk_scan;
        end else begin
            clk_sel = clk_sys;
        end
    end

endmodule

// File: rtl/cfan_lane_gate.sv
`timescale 1ns/1ps
// One output lane: a two-state gate machine clocked on the falling edge of
// the selected clock, plus its true and complement output decode.
module cfan_lane_gate
    import cfan_pkg::*;
(
    input  logic clk_sel,
    input  logic rst_n,
    input  logic dis_lane,
    input  logic dis_all,
    output logic out_t,
    output logic out_c
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        want_park;

    assign want_park = dis_lane | dis_all;

    // Next-state: park and resume transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (want_park) begin
                    state_d = GATE_PARKED;
                end
            end
            GATE_PARKED: begin
                if (!want_park) begin
                    state_d = GATE_OPEN;
                end
            end
        endcase
    end

    // State register: falling edge, so a change only lands while the clock is low.
    always_ff @(negedge clk_sel or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            GATE_OPEN: begin
                out_t = clk_sel;
                out_c = ~clk_sel;
            end
            GATE_PARKED: begin
                out_t = 1'b0;
                out_c = 1'b1;
            end
        endcase
    end

    // R4 / R5: a disable seen at a falling edge leaves the lane parked.
    a_r4_park: assert property (@(negedge clk_sel) disable iff (!rst_n)
        (dis_lane || dis_all) |=> (state_q == GATE_PARKED))
        else $error("a_r4_park");

    // R8: with both disables low at a falling edge, the lane is open afterwards.
    a_r8_resume: assert property (@(negedge clk_sel) disable iff (!rst_n)
        (!dis_lane && !dis_all) |=> (state_q == GATE_OPEN))
        else $error("a_r8_resume");

    // R3: complement is the inverse of the true output.
    a_r3_complement: assert property (@(posedge clk_sel) disable iff (!rst_n)
        (out_c == !out_t))
        else $error("a_r3_complement");

endmodule

// File: rtl/clk_fanout_gated.sv
`timescale 1ns/1ps
// Selectable clock fanout with per-lane falling-edge gating.
module clk_fanout_gated
    import cfan_pkg::*;
#(
    parameter int unsigned LANES = CFAN_LANES
) (
    input  logic             clk_sys,
    input  logic             clk_scan,
    input  logic             src_sel,
    input  logic             rst_n,
    input  logic             dis_all,
    input  logic [LANES-1:0] dis_lane,
    output logic [LANES-1:0] clk_out_t,
    output logic [LANES-1:0] clk_out_c
);

    logic clk_sel;

    cfan_src_mux u_mux (
        .clk_sys  (clk_sys),
        .clk_scan (clk_scan),
        .src_sel  (src_sel),
        .clk_sel  (clk_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cfan_lane_gate u_gate (
            .clk_sel  (clk_sel),
            .rst_n    (rst_n),
            .dis_lane (dis_lane[g]),
            .dis_all  (dis_all),
            .out_t    (clk_out_t[g]),
            .out_c    (clk_out_c[g])
        );

        // R6: a lane output may only rise while the selected clock is high.
        always @(posedge clk_out_t[g]) begin
            if (rst_n) begin
                a_r6_rise_with_clock: assert (clk_sel)
                    else $error("a_r6_rise_with_clock lane %0d", g);
            end
        end
    end

endmodule

// File: tb/tb_clk_fanout_gated.sv
`timescale 1ns/1ps
module tb_clk_fanout_gated;

    localparam int unsigned LANES = 6;
    localparam logic [LANES-1:0] ALL1 = {LANES{1'b1}};
    localparam realtime MIN_HIGH = 9.0;

    logic             clk_sys;
    logic             clk_scan;
    logic             src_sel;
    logic             rst_n;
    logic             dis_all;
    logic [LANES-1:0] dis_lane;
    logic [LANES-1:0] clk_out_t;
    logic [LANES-1:0] clk_out_c;
    logic             sel_ck;
    logic             mon_en;
    logic             done;

    int n_chk;
    int n_bad;

    clk_fanout_gated #(.LANES(LANES)) dut (
        .clk_sys   (clk_sys),
        .clk_scan  (clk_scan),
        .src_sel   (src_sel),
        .rst_n     (rst_n),
        .dis_all   (dis_all),
        .dis_lane  (dis_lane),
        .clk_out_t (clk_out_t),
        .clk_out_c (clk_out_c)
    );

    // 50 MHz system clock; scan clock 60 ns period, offset by 7 ns.
    initial begin
        clk_sys = 1'b0;
        forever #10 clk_sys = ~clk_sys;
    end

    initial begin
        clk_scan = 1'b0;
        #7;
        forever #30 clk_scan = ~clk_scan;
    end

    assign sel_ck = src_sel ? clk_scan : clk_sys;

    task automatic chk(input logic ok, input string req,
                       input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [LANES-1:0] exp);
        chk(clk_out_t == exp, req, clk_out_t, exp);
        chk(clk_out_c == ~exp, {req, " R3"}, clk_out_c, ~exp);
    endtask

    // Sample one high phase and the following low phase.
    task automatic phase_check(input string req, input logic [LANES-1:0] exp);
        @(posedge sel_ck);
        #3;
        chk_out(req, exp);
        @(negedge sel_ck);
        #3;
        chk_out({req, " low"}, '0);
    endtask

    // R6: width monitor on every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_mon
        realtime t_rise;
        logic    armed;
        initial armed = 1'b0;
        always @(posedge clk_out_t[g]) begin
            t_rise = $realtime;
            armed  = mon_en && rst_n;
        end
        always @(negedge clk_out_t[g]) begin
            if (armed && mon_en && rst_n) begin
                n_chk++;
                if (($realtime - t_rise) < MIN_HIGH) begin
                    n_bad++;
                    $display("FAIL R6 lane %0d runt: actual %0t ns expected >= %0t ns",
                             g, $realtime - t_rise, MIN_HIGH);
                end
            end
            armed = 1'b0;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        n_chk    = 0;
        n_bad    = 0;
        done     = 1'b0;
        mon_en   = 1'b0;
        rst_n    = 1'b0;
        src_sel  = 1'b0;
        dis_all  = 1'b0;
        dis_lane = '0;

        // R7: during reset every lane is open.
        phase_check("R7 reset open", ALL1);
        dis_all  = 1'b1;
        dis_lane = ALL1;
        phase_check("R7 reset overrides disables", ALL1);
        dis_lane = '0;
        rst_n    = 1'b1;
        // The first high after release still shows the open state.
        phase_check("R7 first cycle after release", ALL1);
        phase_check("R5 common disable parks all", '0);
        mon_en = 1'b1;

        // R8: resume with dis_all released mid-high.
        @(posedge sel_ck);
        #2;
        dis_all = 1'b0;
        #1;
        chk_out("R8 stays low in current cycle", '0);
        phase_check("R8 resume full pulse", ALL1);

        for (int s = 0; s < 2; s++) begin
            mon_en  = 1'b0;
            src_sel = s[0];
            repeat (3) @(negedge sel_ck);
            #3;
            mon_en = 1'b1;

            if (s == 0) begin
                wait (clk_sys && !clk_scan);
                #1;
                chk_out("R1 follows clk_sys high", ALL1);
                wait (!clk_sys && clk_scan);
                #1;
                chk_out("R1 ignores clk_scan", '0);
            end else begin
                wait (clk_scan && !clk_sys);
                #1;
                chk_out("R2 follows clk_scan high", ALL1);
                wait (!clk_scan && clk_sys);
                #1;
                chk_out("R2 ignores clk_sys", '0);
            end

            // R4 per lane, disable and re-enable mid-high.
            for (int i = 0; i < LANES; i++) begin
                logic [LANES-1:0] m;
                m = ALL1 & ~(LANES'(1) << i);
                @(posedge sel_ck);
                #2;
                dis_lane[i] = 1'b1;
                #1;
                chk_out("R6 pulse completes after mid-high disable", ALL1);
                @(negedge sel_ck);
                #3;
                chk_out("R4 low after falling edge", '0);
                phase_check("R4 lane parked, others run", m);
                @(posedge sel_ck);
                #2;
                dis_lane[i] = 1'b0;
                #1;
                chk_out("R8 parked lane stays low this cycle", m);
                phase_check("R8 lane resumes", ALL1);
            end

            // R5: common disable wins over a partial lane pattern.
            dis_lane = 6'b101010;
            phase_check("R6 low-phase change waits a cycle", ALL1);
            phase_check("R4 pattern 101010", 6'b010101);
            dis_all = 1'b1;
            phase_check("R6 dis_all waits a cycle", 6'b010101);
            phase_check("R5 dis_all parks all", '0);
            dis_all  = 1'b0;
            dis_lane = '0;
            phase_check("R6 release waits a cycle", '0);
            phase_check("R8 all resume", ALL1);

            // R4 / R6: every disable pattern, changed while the clock is low.
            for (int p = 0; p < (1 << LANES); p++) begin
                logic [LANES-1:0] prev;
                prev     = dis_lane;
                dis_lane = LANES'(p);
                phase_check("R6 old gating for one more high phase", ~prev);
                phase_check("R4 new pattern", ~LANES'(p));
            end
            dis_lane = '0;
            phase_check("R6 settle", ~LANES'((1 << LANES) - 1));
            phase_check("R8 all open", ALL1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule